// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is the registering stage on a memory address and command bus. It captures a shared data bus together with a small set of per-rank control bits on every rising clock edge. The captured values drive the bus toward the memory devices.

To save switching power when no rank is addressed, the stage can freeze. The gating-enable input and every rank chip-select input are all sampled high (deselected) on a clock edge. On that edge nothing is loaded and all outputs keep their previous values. When any of those inputs is low, the stage loads normally. A synchronous active-low reset clears every output and overrides the freeze.

A static mapping input picks the order in which the shared bus reaches the output pins. It can be a straight order or a mirrored order, which suits modules that are fitted on either side of a board. The per-rank control bits are never remapped. The freeze is a load enable on ordinary flops, so the block uses a single clock domain and has no gated clocks.

Top module: `cmd_gated_reg`

## Requirements
- R1: On a rising edge where rst_n is 1, gate_en is 1 and every bit of rank_cs_n is 1, all outputs (q_bus, q_cs_n, q_cke, q_odt) keep the values they had before that edge.
- R2: On a rising edge where rst_n is 1 and gate_en or any rank_cs_n bit is 0, all outputs take the values derived from the inputs sampled at that edge, one cycle after they are presented.
- R3: On a rising edge where rst_n is 0, every output bit becomes 0, whatever the gating inputs are, including when the freeze condition of R1 holds.
- R4: With gate_en at 0, the chip-select bits act as ordinary data. The outputs load on every edge, including edges where all rank_cs_n bits are 1.
- R5: The per-rank bits rank_cs_n, rank_cke and rank_odt are registered alongside the bus with the same load decision. Bit r of each output equals bit r of its input, in both mapping modes.
- R6: With map_sel at 0 (straight order), a load gives q_bus[i] = d_bus[i] for every i.
- R7: With map_sel at 1 (mirrored order), a load gives q_bus[i] = d_bus[DATA_W-1-i] for every i.
- R8: The freeze decision uses the gating inputs present at the same edge that would load. On the first edge after a frozen period where any gating input is 0, the outputs take the inputs of that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_en | input | 1 | 1 enables freezing when all ranks are deselected |
| map_sel | input | 1 | Static bus order select: 0 straight, 1 mirrored |
| d_bus | input | DATA_W | Shared address/command bits |
| rank_cs_n | input | NRANK | Per-rank chip selects, active low |
| rank_cke | input | NRANK | Per-rank clock enables |
| rank_odt | input | NRANK | Per-rank termination controls |
| q_bus | output | DATA_W | Registered, mapped shared bits |
| q_cs_n | output | NRANK | Registered chip selects |
| q_cke | output | NRANK | Registered clock enables |
| q_odt | output | NRANK | Registered termination controls |

## Verification
The assertions check three things on every cycle: the freeze of all outputs under the full deselect condition, the one-cycle load path for the rank bits and the bus in each mapping order, and reset clearing the outputs even while frozen. The bench scenarios cover the order of events that a single-edge property cannot frame well. These are long frozen stretches with changing inputs, release through one chip select versus through the gating enable, reset arriving mid-freeze, and a change of mapping under reset. A behavioural model follows each of them and is compared every cycle.

// File: rtl/cmdreg_pkg.sv
// Shared definitions for the chip-select gated command register.
// Assumes: the mapping select is static during operation.
package cmdreg_pkg;

    // Bus order applied to the shared bits before registering.
    typedef enum logic {
        MAP_STRAIGHT = 1'b0,
        MAP_MIRROR   = 1'b1
    } map_mode_e;

    // Default geometry.
    localparam int DEF_DATA_W = 16;
    localparam int DEF_NRANK  = 2;

endpackage

// File: rtl/cmdreg_gate_ctrl.sv
// Load-enable generator: the register loads unless gating is enabled
// and every rank is deselected (chip selects active low).
// Assumes: inputs are synchronous to the register clock.
module cmdreg_gate_ctrl #(
    parameter int NRANK = 2
) (
    input  logic             gate_en,
    input  logic [NRANK-1:0] cs_n,
    output logic             load_en
);

    logic all_idle;

    // Detect that no rank is selected on this edge.
    always_comb begin
        all_idle = &cs_n;
    end

    // Freeze only when gating is on and all ranks are idle.
    always_comb begin
        load_en = !(gate_en && all_idle);
    end

endmodule

// File: rtl/cmdreg_lane_map.sv
// Bus order selector: passes the shared bits straight or mirrored.
// Assumes: map_sel is held static while the register is in use.
module cmdreg_lane_map
    import cmdreg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              map_sel,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out
);

    localparam int TOP = DATA_W - 1;

    map_mode_e mode;

    // Decode the static mapping select.
    always_comb begin
        mode = map_mode_e'(map_sel);
    end

    // One selector per lane: straight bit or its mirrored partner.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        always_comb begin
            d_out[i] = (mode == MAP_MIRROR) ? d_in[TOP-i] : d_in[i];
        end
    end

endmodule

// File: rtl/cmdreg_hold_reg.sv
// Register bank with a load enable and a synchronous active-low clear.
// Reset wins over the enable. No clock gating is used.
// Assumes: single clock domain.
module cmdreg_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Clear on reset, else load when enabled, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cmd_gated_reg.sv
// Top: chip-select gated command register. Maps the shared bus, then
// registers it with the per-rank bits under one common load enable.
// Assumes: map_sel static; all inputs synchronous to clk.
module cmd_gated_reg
    import cmdreg_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int NRANK  = DEF_NRANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              map_sel,
    input  logic [DATA_W-1:0] d_bus,
    input  logic [NRANK-1:0]  rank_cs_n,
    input  logic [NRANK-1:0]  rank_cke,
    input  logic [NRANK-1:0]  rank_odt,
    output logic [DATA_W-1:0] q_bus,
    output logic [NRANK-1:0]  q_cs_n,
    output logic [NRANK-1:0]  q_cke,
    output logic [NRANK-1:0]  q_odt
);

    localparam int CTRL_W  = 3 * NRANK;
    localparam int TOTAL_W = DATA_W + CTRL_W;

    logic               load_en;
    logic [DATA_W-1:0]  bus_mapped;
    logic [TOTAL_W-1:0] stage_d;
    logic [TOTAL_W-1:0] stage_q;

    cmdreg_gate_ctrl #(.NRANK(NRANK)) u_gate (
        .gate_en (gate_en),
        .cs_n    (rank_cs_n),
        .load_en (load_en)
    );

    cmdreg_lane_map #(.DATA_W(DATA_W)) u_map (
        .map_sel (map_sel),
        .d_in    (d_bus),
        .d_out   (bus_mapped)
    );

    // Pack the mapped bus and rank bits into one register word.
    always_comb begin
        stage_d = {rank_odt, rank_cke, rank_cs_n, bus_mapped};
    end

    cmdreg_hold_reg #(.WIDTH(TOTAL_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .d       (stage_d),
        .q       (stage_q)
    );

    // Unpack the register word onto the output ports.
    always_comb begin
        q_bus  = stage_q[DATA_W-1:0];
        q_cs_n = stage_q[DATA_W +: NRANK];
        q_cke  = stage_q[DATA_W+NRANK +: NRANK];
        q_odt  = stage_q[DATA_W+2*NRANK +: NRANK];
    end

endmodule

// File: rtl/cmd_gated_reg_chk.sv
// Checker for cmd_gated_reg: freeze, load path, mapping and reset rules.
// Attached by bind below; observes ports only.
module cmd_gated_reg_chk #(
    parameter int DATA_W = 16,
    parameter int NRANK  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_en,
    input logic              map_sel,
    input logic [DATA_W-1:0] d_bus,
    input logic [NRANK-1:0]  rank_cs_n,
    input logic [NRANK-1:0]  rank_cke,
    input logic [NRANK-1:0]  rank_odt,
    input logic [DATA_W-1:0] q_bus,
    input logic [NRANK-1:0]  q_cs_n,
    input logic [NRANK-1:0]  q_cke,
    input logic [NRANK-1:0]  q_odt
);

    logic [DATA_W-1:0] mirrored;
    logic              frozen;

    // Mirrored view of the input bus, as the requirement states it.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mirrored[i] = d_bus[DATA_W-1-i];
        end
    end

    // Full deselect condition.
    always_comb begin
        frozen = gate_en && (&rank_cs_n);
    end

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> ($stable(q_bus) && $stable(q_cs_n) && $stable(q_cke) && $stable(q_odt))); // R1

    AST_RANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !frozen |=> (q_cs_n == $past(rank_cs_n) && q_cke == $past(rank_cke) && q_odt == $past(rank_odt))); // R2

    AST_UNGATED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (q_cs_n == $past(rank_cs_n))); // R4

    AST_BUS_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !map_sel) |=> (q_bus == $past(d_bus))); // R6

    AST_BUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && map_sel) |=> (q_bus == $past(mirrored))); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q_bus == '0 && q_cs_n == '0 && q_cke == '0 && q_odt == '0)); // R3

endmodule

bind cmd_gated_reg cmd_gated_reg_chk #(.DATA_W(DATA_W), .NRANK(NRANK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_en   (gate_en),
    .map_sel   (map_sel),
    .d_bus     (d_bus),
    .rank_cs_n (rank_cs_n),
    .rank_cke  (rank_cke),
    .rank_odt  (rank_odt),
    .q_bus     (q_bus),
    .q_cs_n    (q_cs_n),
    .q_cke     (q_cke),
    .q_odt     (q_odt)
);

// File: tb/cmd_gated_reg_tb.sv
// Bench for cmd_gated_reg: behavioural model compared on every clock.
module cmd_gated_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_en = 1'b0;
    logic          map_sel = 1'b0;
    logic [DW-1:0] d_bus = '0;
    logic [NR-1:0] rank_cs_n = '0;
    logic [NR-1:0] rank_cke = '0;
    logic [NR-1:0] rank_odt = '0;
    logic [DW-1:0] q_bus;
    logic [NR-1:0] q_cs_n, q_cke, q_odt;

    logic [DW-1:0] m_bus = '0;
    logic [NR-1:0] m_cs = '0, m_cke = '0, m_odt = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_gated_reg #(.DATA_W(DW), .NRANK(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .map_sel(map_sel),
        .d_bus(d_bus), .rank_cs_n(rank_cs_n), .rank_cke(rank_cke),
        .rank_odt(rank_odt), .q_bus(q_bus), .q_cs_n(q_cs_n),
        .q_cke(q_cke), .q_odt(q_odt)
    );

    // Randomise the non-gating inputs.
    task automatic scramble();
        d_bus    = DW'($urandom);
        rank_cke = NR'($urandom);
        rank_odt = NR'($urandom);
    endtask

    // Advance one edge, update the model, compare at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_bus = '0; m_cs = '0; m_cke = '0; m_odt = '0;
        end else if (!(gate_en && rank_cs_n == '1)) begin
            for (int i = 0; i < DW; i++)
                m_bus[i] = map_sel ? d_bus[DW-1-i] : d_bus[i];
            m_cs = rank_cs_n; m_cke = rank_cke; m_odt = rank_odt;
        end
        @(negedge clk);
        checks++;
        if (q_bus !== m_bus || q_cs_n !== m_cs || q_cke !== m_cke || q_odt !== m_odt) begin
            errors++;
            $display("FAIL %s actual bus=%h cs=%b cke=%b odt=%b expected bus=%h cs=%b cke=%b odt=%b",
                     tag, q_bus, q_cs_n, q_cke, q_odt, m_bus, m_cs, m_cke, m_odt);
        end
    endtask

    initial begin
        // R3: reset while the freeze condition holds still clears.
        gate_en = 1'b1; rank_cs_n = '1; scramble();
        for (int k = 0; k < 3; k++) step("R3");
        @(negedge clk);
        rst_n = 1'b1;
        // R2 / R5 / R6: normal loads, straight order, rank selected.
        for (int k = 0; k < 8; k++) begin
            scramble(); rank_cs_n = NR'($urandom) & ~NR'(k % 3 + 1);
            step("R2 R5 R6");
        end
        // R1: frozen stretch with changing inputs.
        rank_cs_n = '1;
        for (int k = 0; k < 6; k++) begin scramble(); step("R1"); end
        // R8: one chip select falls; that edge loads.
        scramble(); rank_cs_n = 2'b10; step("R8");
        rank_cs_n = '1; scramble(); step("R1");
        scramble(); rank_cs_n = 2'b01; step("R8");
        // R4: gating disabled, all deselected still loads.
        gate_en = 1'b0; rank_cs_n = '1;
        for (int k = 0; k < 5; k++) begin scramble(); step("R4"); end
        // R8: release by gate_en after a freeze.
        gate_en = 1'b1; scramble(); step("R1");
        gate_en = 1'b0; scramble(); step("R8");
        // R3: reset mid-freeze, then mapping change under reset.
        gate_en = 1'b1; rank_cs_n = '1; scramble(); step("R1");
        rst_n = 1'b0; map_sel = 1'b1; scramble(); step("R3");
        step("R3");
        rst_n = 1'b1;
        // R7: mirrored order loads.
        for (int k = 0; k < 8; k++) begin
            scramble(); rank_cs_n = 2'b00; step("R7 R5");
        end
        d_bus = 16'h0001; step("R7");
        d_bus = 16'hF0A5; step("R7");
        // R1 in mirrored mode, then release.
        rank_cs_n = '1;
        for (int k = 0; k < 4; k++) begin scramble(); step("R1"); end
        scramble(); rank_cs_n = 2'b00; step("R8 R7");
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule